// File: doc/BRIEF.md
# Disk Address Mark Detector

This block sits behind a disk data separator and looks for the sync pattern that opens each record on the medium. Two serial streams arrive from the separator: the recovered data bits and the recovered clock bits. A per-bit strobe tells the block when a new bit of each stream is valid. Everything runs in one system clock domain.

Each stream is shifted into its own window register. The newest bit enters at bit 0, so the window always holds the eight most recent bits. A match can therefore occur at any bit alignment. The record start is recognised only when two things hold at the same bit time:

- the data window equals 0xA1, and
- the clock window equals 0x0A, the pattern with missing clock bits.

The processor arms the search with a level input. When the data match and the clock match occur together while the search is armed, a sticky found flag is raised. That flag starts the byte-assembly logic downstream, which keeps using the data window; the clock window has served its purpose by then. The flag stays high until the processor drops the search input.

Top module: `amd_detector`

## Requirements
- R1: A synchronous active-high reset clears both windows to 0x00 and the found flag to 0 at the next clock edge.
- R2: On a clock edge with `bit_en` high, `data_window` becomes `{data_window[6:0], data_bit}`, so the newest bit is at bit 0. On an edge with `bit_en` low, `data_window` keeps its value.
- R3: On a clock edge with `bit_en` high, `clk_window` becomes `{clk_window[6:0], clk_bit}`. On an edge with `bit_en` low, `clk_window` keeps its value.
- R4: The found flag is never raised when only one window matches: a data window of 0xA1 with any other clock window, or a clock window of 0x0A with any other data window, leaves it at 0.
- R5: Take the strobe edge after which `data_window` is 0xA1 and `clk_window` is 0x0A, with `search` high. `mark_found` goes to 1 at the clock edge that follows it, not at the strobe edge itself. This holds whatever number of bits preceded the mark.
- R6: Once `mark_found` is 1, it stays 1 on every edge where `search` was high, whatever later bits arrive.
- R7: On every edge where `search` is low, `mark_found` becomes 0, and matching windows do not set it.
- R8: The windows keep shifting on strobes while `search` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Bit strobe: one-cycle pulse per recovered bit |
| data_bit | input | 1 | Recovered data stream bit |
| clk_bit | input | 1 | Recovered clock stream bit |
| search | input | 1 | Arms detection when high; clears the found flag when low |
| data_window | output | 8 | Eight most recent data bits, newest at bit 0 |
| clk_window | output | 8 | Eight most recent clock bits, newest at bit 0 |
| mark_found | output | 1 | Sticky address-mark found flag |

## Verification
The bench feeds the data mark with a wrong clock pattern, and the clock mark with a wrong data byte. A design that combined the two comparisons with OR, or looked at only one of them, would raise the flag on these half matches.

It places the mark after an odd number of leading bits and samples the flag one cycle before and one cycle after the expected set edge. This exposes a shift in the wrong direction, a comparison fixed to byte boundaries, and an off-by-one cycle in the set path.

It keeps shifting unrelated bytes after the flag is set, then drops the search input, and then presents a full mark while the search is still low. A flag that is not sticky, is not cleared by the search input, or ignores the search input would show up in these steps.

// File: rtl/amd_pkg.sv
package amd_pkg;

    localparam int unsigned MARK_W = 8;

    localparam logic [MARK_W-1:0] DATA_MARK_DEF = 8'hA1;
    localparam logic [MARK_W-1:0] CLK_MARK_DEF  = 8'h0A;

    // Stream indices for the generated window registers
    localparam int unsigned STREAM_DATA = 0;
    localparam int unsigned STREAM_CLK  = 1;
    localparam int unsigned N_STREAMS   = 2;

    typedef struct packed {
        logic data_hit;
        logic clk_hit;
    } hit_t;

    typedef enum logic {
        LATCH_OPEN   = 1'b0,
        LATCH_LOCKED = 1'b1
    } latch_state_t;

    function automatic logic mark_coincident(hit_t h);
        return h.data_hit & h.clk_hit;
    endfunction

endpackage

// File: rtl/amd_shift_window.sv
module amd_shift_window #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         din,
    output logic [W-1:0] window
);

    always_ff @(posedge clk) begin
        if (rst) begin
            window <= '0;
        end else if (en) begin
            window <= {window[W-2:0], din};
        end
    end

endmodule

// File: rtl/amd_pattern_match.sv
module amd_pattern_match
    import amd_pkg::*;
#(
    parameter int unsigned   W          = 8,
    parameter logic [W-1:0]  DATA_MARK  = DATA_MARK_DEF,
    parameter logic [W-1:0]  CLK_MARK   = CLK_MARK_DEF
) (
    input  logic [W-1:0] data_win,
    input  logic [W-1:0] clk_win,
    output hit_t         hits
);

    always_comb begin
        hits.data_hit = (data_win == DATA_MARK);
        hits.clk_hit  = (clk_win == CLK_MARK);
    end

endmodule

// File: rtl/amd_mark_latch.sv
module amd_mark_latch
    import amd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic search,
    input  hit_t hits,
    output logic found
);

    latch_state_t state_q;
    latch_state_t state_d;

    always_comb begin
        state_d = state_q;
        if (!search) begin
            state_d = LATCH_OPEN;
        end else if (mark_coincident(hits)) begin
            state_d = LATCH_LOCKED;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LATCH_OPEN;
        end else begin
            state_q <= state_d;
        end
    end

    assign found = (state_q == LATCH_LOCKED);

endmodule

// File: rtl/amd_detector.sv
module amd_detector
    import amd_pkg::*;
#(
    parameter int unsigned   W          = MARK_W,
    parameter logic [W-1:0]  DATA_MARK  = DATA_MARK_DEF,
    parameter logic [W-1:0]  CLK_MARK   = CLK_MARK_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         bit_en,
    input  logic         data_bit,
    input  logic         clk_bit,
    input  logic         search,
    output logic [W-1:0] data_window,
    output logic [W-1:0] clk_window,
    output logic         mark_found
);

    logic [N_STREAMS-1:0] serial_in;
    logic [W-1:0]         windows [N_STREAMS];
    hit_t                 hits;

    assign serial_in[STREAM_DATA] = data_bit;
    assign serial_in[STREAM_CLK]  = clk_bit;

    for (genvar s = 0; s < N_STREAMS; s++) begin : g_stream
        amd_shift_window #(.W(W)) u_win (
            .clk    (clk),
            .rst    (rst),
            .en     (bit_en),
            .din    (serial_in[s]),
            .window (windows[s])
        );
    end

    assign data_window = windows[STREAM_DATA];
    assign clk_window  = windows[STREAM_CLK];

    amd_pattern_match #(
        .W         (W),
        .DATA_MARK (DATA_MARK),
        .CLK_MARK  (CLK_MARK)
    ) u_match (
        .data_win (data_window),
        .clk_win  (clk_window),
        .hits     (hits)
    );

    amd_mark_latch u_latch (
        .clk    (clk),
        .rst    (rst),
        .search (search),
        .hits   (hits),
        .found  (mark_found)
    );

endmodule

// File: rtl/amd_detector_chk.sv
module amd_detector_chk #(
    parameter int unsigned   W          = 8,
    parameter logic [W-1:0]  DATA_MARK  = 8'hA1,
    parameter logic [W-1:0]  CLK_MARK   = 8'h0A
) (
    input logic         clk,
    input logic         rst,
    input logic         bit_en,
    input logic         data_bit,
    input logic         clk_bit,
    input logic         search,
    input logic [W-1:0] data_window,
    input logic [W-1:0] clk_window,
    input logic         mark_found
);

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (data_window == '0 && clk_window == '0 && !mark_found));

    p_data_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> $stable(data_window));

    p_data_shift_r2: assert property (@(posedge clk) disable iff (rst)
        bit_en |=> data_window[0] == $past(data_bit));

    p_clk_shift_r3: assert property (@(posedge clk) disable iff (rst)
        bit_en |=> clk_window[0] == $past(clk_bit));

    p_set_needs_both_r4: assert property (@(posedge clk) disable iff (rst)
        (!mark_found && !(data_window == DATA_MARK && clk_window == CLK_MARK))
        |=> !mark_found);

    p_set_on_mark_r5: assert property (@(posedge clk) disable iff (rst)
        (search && data_window == DATA_MARK && clk_window == CLK_MARK)
        |=> mark_found);

    p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (mark_found && search) |=> mark_found);

    p_search_clears_r7: assert property (@(posedge clk) disable iff (rst)
        !search |=> !mark_found);

endmodule

bind amd_detector amd_detector_chk #(
    .W         (W),
    .DATA_MARK (DATA_MARK),
    .CLK_MARK  (CLK_MARK)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bit_en      (bit_en),
    .data_bit    (data_bit),
    .clk_bit     (clk_bit),
    .search      (search),
    .data_window (data_window),
    .clk_window  (clk_window),
    .mark_found  (mark_found)
);

// File: tb/amd_detector_tb_top.sv
module amd_detector_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       bit_en;
    logic       data_bit;
    logic       clk_bit;
    logic       search;
    logic [7:0] data_window;
    logic [7:0] clk_window;
    logic       mark_found;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    amd_detector dut_i (
        .clk         (clk),
        .rst         (rst),
        .bit_en      (bit_en),
        .data_bit    (data_bit),
        .clk_bit     (clk_bit),
        .search      (search),
        .data_window (data_window),
        .clk_window  (clk_window),
        .mark_found  (mark_found)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One strobe: the shift happens at the posedge inside; returns at the next negedge
    task automatic send_bit(input logic d, input logic c);
        data_bit = d;
        clk_bit  = c;
        bit_en   = 1'b1;
        @(negedge clk);
        bit_en   = 1'b0;
    endtask

    // Sends the byte MSB first, so the window ends equal to the byte
    task automatic send_byte(input logic [7:0] d, input logic [7:0] c);
        for (int i = 7; i >= 0; i--) send_bit(d[i], c[i]);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 data_window", data_window, 8'h00);
        chk("R1 clk_window", clk_window, 8'h00);
        chk("R1 mark_found", mark_found, 0);
    endtask

    task automatic t_shift();
        search = 1'b0;
        send_byte(8'h5C, 8'h33);
        chk("R2 data shift", data_window, 8'h5C);
        chk("R3 clk shift", clk_window, 8'h33);
        send_bit(1'b1, 1'b0);
        chk("R2 newest at bit0", data_window, 8'hB9);
        chk("R3 newest at bit0", clk_window, 8'h66);
        idle(3);
        chk("R2 hold without strobe", data_window, 8'hB9);
        chk("R3 hold without strobe", clk_window, 8'h66);
    endtask

    task automatic t_half_match();
        do_reset();
        search = 1'b1;
        send_byte(8'hA1, 8'h00);
        idle(2);
        chk("R4 data-only match", mark_found, 0);
        send_byte(8'h00, 8'h0A);
        idle(2);
        chk("R4 clock-only match", mark_found, 0);
        send_byte(8'hA1, 8'h0B);
        idle(2);
        chk("R4 near clock match", mark_found, 0);
    endtask

    task automatic t_mark_aligned_odd();
        do_reset();
        search = 1'b1;
        send_bit(1'b1, 1'b1);
        send_bit(1'b0, 1'b1);
        send_bit(1'b1, 1'b1);
        send_byte(8'hA1, 8'h0A);
        chk("R5 not yet set at strobe edge", mark_found, 0);
        idle(1);
        chk("R5 set one edge later", mark_found, 1);
    endtask

    task automatic t_sticky();
        send_byte(8'hFF, 8'hFF);
        send_byte(8'h12, 8'h34);
        idle(2);
        chk("R6 sticky after more bytes", mark_found, 1);
    endtask

    task automatic t_search_drop();
        search = 1'b0;
        idle(1);
        chk("R7 cleared by search low", mark_found, 0);
        send_byte(8'hA1, 8'h0A);
        idle(2);
        chk("R7 match ignored while search low", mark_found, 0);
        chk("R8 data shifts while search low", data_window, 8'hA1);
        chk("R8 clk shifts while search low", clk_window, 8'h0A);
        send_bit(1'b0, 1'b0);
        search = 1'b1;
        idle(2);
        chk("R4 rearmed without mark", mark_found, 0);
    endtask

    task automatic t_reset_mid();
        send_byte(8'hA1, 8'h0A);
        idle(1);
        chk("R5 set again", mark_found, 1);
        do_reset();
        chk("R1 reset clears flag", mark_found, 0);
        chk("R1 reset clears data", data_window, 8'h00);
    endtask

    initial begin
        rst = 1'b1; bit_en = 1'b0; data_bit = 1'b0; clk_bit = 1'b0; search = 1'b0;
        @(negedge clk);
        t_reset();
        t_shift();
        t_half_match();
        t_mark_aligned_odd();
        t_sticky();
        t_search_drop();
        t_reset_mid();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule